// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit processor with one branch delay slot fetches from after a control-flow instruction, and whether that instruction writes a return address. Each cycle it takes the program counter of the instruction being resolved, a decoded control-flow operation code, the 16-bit branch displacement, the 26-bit absolute jump field and the two source register values. One clock later it presents the resolved next program counter, a taken flag, a link write enable, the link destination register index and the link value.

Branches compare the first operand with the second for equality or inequality, or compare the first operand alone with zero as a signed two's-complement number. Two of the compare-with-zero branches also link, and they link only when they are taken. Jumps either splice the 26-bit field into the upper bits of the sequential address or take the whole target from a register. Every link writes the address two instructions past the control-flow instruction into register 31, because the instruction right after it (the delay slot) always runs.

Top module: `flow_npc_unit`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `nextPc`, `taken`, `linkWe`, `linkDest` and `linkVal` are all zero.
- R2: Outputs are registered: the result for inputs applied before a rising edge appears after that edge. When `taken` is 0, `nextPc` equals the sampled `pcIn` + 4.
- R3: A taken branch sets `nextPc` to `pcIn` + 4 + (sign-extended `offset` × 4); offsets with bit 15 set move backwards.
- R4: Code 1 (equal) is taken when `rsVal` == `rtVal`; code 2 (not equal) is taken when they differ, all 32 bits compared.
- R5: Codes 3 (rs <= 0), 4 (rs > 0), 5 (rs < 0) and 6 (rs >= 0) treat `rsVal` as signed two's complement and ignore `rtVal`.
- R6: Code 7 (rs < 0, link) and code 8 (rs >= 0, link) set `taken` and `linkWe` together only when their condition holds; otherwise both are 0.
- R7: Whenever `linkWe` is 1, `linkDest` is 31 and `linkVal` is `pcIn` + 8; when `linkWe` is 0, `linkDest` is 0.
- R8: Code 9 (jump) and code 10 (jump and link, always links) set `nextPc` to {bits 31:28 of `pcIn` + 4, `target`, 2'b00}; the upper bits come from `pcIn` + 4, not `pcIn`.
- R9: Code 11 (register jump) and code 12 (register jump and link, always links) set `nextPc` to `rsVal` unchanged and `taken` to 1.
- R10: Code 0 and the unused codes 13 to 15 give `taken` 0, `linkWe` 0 and `nextPc` = `pcIn` + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| pcIn | input | 32 | Address of the instruction being resolved |
| opCode | input | 4 | Control-flow operation code (0 to 12, see requirements) |
| offset | input | 16 | Signed branch displacement in instructions |
| target | input | 26 | Absolute jump field in instructions |
| rsVal | input | 32 | First register operand, also register jump address |
| rtVal | input | 32 | Second register operand for equal / not equal |
| nextPc | output | 32 | Resolved fetch address after the delay slot |
| taken | output | 1 | Control flow leaves the sequential path |
| linkWe | output | 1 | Write the return address to the link register |
| linkDest | output | 5 | Link register index (31 when linking) |
| linkVal | output | 32 | Return address, `pcIn` + 8 |

## Verification
A wrong condition select or a swapped compare sense shows up at the very next edge as a flipped `taken` together with `nextPc` landing on the branch target instead of `pcIn` + 4, so each case is judged one cycle after it is driven. Corrupted link strobes show as `linkWe` rising on a not-taken conditional link branch or failing to rise on an unconditional link jump, again within one cycle. The signed boundary values 0, -1, 1 and the most negative number, and a jump whose `pcIn` + 4 carries into bit 28, expose sign and upper-bit errors that ordinary values hide.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Operation codes presented by the decoder
  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_BEQ    = 4'd1,
    OP_BNE    = 4'd2,
    OP_BLEZ   = 4'd3,
    OP_BGTZ   = 4'd4,
    OP_BLTZ   = 4'd5,
    OP_BGEZ   = 4'd6,
    OP_BLTZL  = 4'd7,
    OP_BGEZL  = 4'd8,
    OP_JABS   = 4'd9,
    OP_JABSL  = 4'd10,
    OP_JREG   = 4'd11,
    OP_JREGL  = 4'd12
  } flowOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selEq;
    logic selNe;
    logic selLez;
    logic selGtz;
    logic selLtz;
    logic selGez;
    logic isBranch;
    logic isJump;
    logic isJumpReg;
    logic linkAlways;
    logic linkOnCond;
  } flowStrobe_t;

endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  opCode,
  output flowStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    case (flowOp_e'(opCode))
      OP_BEQ:   begin strobe.isBranch = 1'b1; strobe.selEq  = 1'b1; end
      OP_BNE:   begin strobe.isBranch = 1'b1; strobe.selNe  = 1'b1; end
      OP_BLEZ:  begin strobe.isBranch = 1'b1; strobe.selLez = 1'b1; end
      OP_BGTZ:  begin strobe.isBranch = 1'b1; strobe.selGtz = 1'b1; end
      OP_BLTZ:  begin strobe.isBranch = 1'b1; strobe.selLtz = 1'b1; end
      OP_BGEZ:  begin strobe.isBranch = 1'b1; strobe.selGez = 1'b1; end
      OP_BLTZL: begin
        strobe.isBranch   = 1'b1;
        strobe.selLtz     = 1'b1;
        strobe.linkOnCond = 1'b1;
      end
      OP_BGEZL: begin
        strobe.isBranch   = 1'b1;
        strobe.selGez     = 1'b1;
        strobe.linkOnCond = 1'b1;
      end
      OP_JABS:  strobe.isJump = 1'b1;
      OP_JABSL: begin strobe.isJump = 1'b1; strobe.linkAlways = 1'b1; end
      OP_JREG:  strobe.isJumpReg = 1'b1;
      OP_JREGL: begin strobe.isJumpReg = 1'b1; strobe.linkAlways = 1'b1; end
      default:  strobe = '0;  // R10: sequential flow
    endcase
  end

  // R4 R5: a branch selects exactly one condition, anything else none
  cond_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isBranch |-> $onehot({strobe.selEq, strobe.selNe, strobe.selLez,
                                 strobe.selGtz, strobe.selLtz, strobe.selGez}))
    else $error("condition select not one-hot on branch");

  // R10
  cond_sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.isBranch |-> ({strobe.selEq, strobe.selNe, strobe.selLez,
                           strobe.selGtz, strobe.selLtz, strobe.selGez} == 6'b0)
                         && !strobe.linkOnCond)
    else $error("condition select active without branch");

  // R8 R9: at most one flow kind per operation
  flow_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.isBranch, strobe.isJump, strobe.isJumpReg}))
    else $error("multiple flow kinds");

endmodule

// File: rtl/flow_cond.sv
module flow_cond
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  flowStrobe_t       strobe,
  output logic              condMet
);

  logic opsEqual;
  logic rsNeg;
  logic rsZero;
  logic rsNotPos;

  assign opsEqual = (rsVal == rtVal);
  assign rsNeg    = rsVal[DATA_W-1];
  assign rsZero   = (rsVal == '0);
  assign rsNotPos = rsNeg | rsZero;

  always_comb begin
    condMet = (strobe.selEq  &  opsEqual)
            | (strobe.selNe  & ~opsEqual)
            | (strobe.selLez &  rsNotPos)
            | (strobe.selGtz & ~rsNotPos)
            | (strobe.selLtz &  rsNeg)
            | (strobe.selGez & ~rsNeg);
  end

endmodule

// File: rtl/flow_dp.sv
module flow_dp
  import npc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int TGT_W     = 26,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31,
  parameter int INSN_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    pcIn,
  input  logic [OFF_W-1:0]     offset,
  input  logic [TGT_W-1:0]     target,
  input  logic [ADDR_W-1:0]    rsVal,
  input  logic [ADDR_W-1:0]    rtVal,
  input  flowStrobe_t          strobe,
  output logic [ADDR_W-1:0]    nextPc,
  output logic                 taken,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkDest,
  output logic [ADDR_W-1:0]    linkVal
);

  localparam int SHIFT_W  = $clog2(INSN_BYTES);
  localparam int UPPER_W  = ADDR_W - TGT_W - SHIFT_W;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP2    = ADDR_W'(2 * INSN_BYTES);
  localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

  logic [ADDR_W-1:0] seqPc;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] jumpTgt;
  logic [ADDR_W-1:0] pickTgt;
  logic              condMet;
  logic              takeNow;
  logic              linkNow;
  logic              warm;

  flow_cond #(.DATA_W(ADDR_W)) uCond (
    .rsVal  (rsVal),
    .rtVal  (rtVal),
    .strobe (strobe),
    .condMet(condMet)
  );

  assign seqPc     = pcIn + STEP;
  assign offExt    = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign branchTgt = seqPc + (offExt << SHIFT_W);

  generate
    if (UPPER_W > 0) begin : gUpper
      assign jumpTgt = {seqPc[ADDR_W-1 -: UPPER_W], target, {SHIFT_W{1'b0}}};
    end else begin : gNoUpper
      assign jumpTgt = ADDR_W'({target, {SHIFT_W{1'b0}}});
    end
  endgenerate

  always_comb begin
    if (strobe.isJumpReg)   pickTgt = rsVal;
    else if (strobe.isJump) pickTgt = jumpTgt;
    else                    pickTgt = branchTgt;
  end

  assign takeNow = strobe.isJump | strobe.isJumpReg | (strobe.isBranch & condMet);
  assign linkNow = strobe.linkAlways | (strobe.linkOnCond & condMet);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc   <= '0;
      taken    <= 1'b0;
      linkWe   <= 1'b0;
      linkDest <= '0;
      linkVal  <= '0;
      warm     <= 1'b0;
    end else begin
      nextPc   <= takeNow ? pickTgt : seqPc;
      taken    <= takeNow;
      linkWe   <= linkNow;
      linkDest <= linkNow ? LINK_IDX : '0;
      linkVal  <= linkNow ? pcIn + STEP2 : '0;
      warm     <= 1'b1;
    end
  end

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !taken) |-> (nextPc == $past(pcIn) + STEP))
    else $error("sequential next pc wrong");

  // R7
  link_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && linkWe) |-> (linkVal == $past(pcIn) + STEP2 && linkDest == LINK_IDX))
    else $error("link value or destination wrong");

  // R6
  link_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> taken)
    else $error("link without taken flow");

  // R9
  jr_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(strobe.isJumpReg)) |-> (taken && nextPc == $past(rsVal)))
    else $error("register jump target wrong");

endmodule

// File: rtl/flow_npc_unit.sv
module flow_npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int TGT_W     = 26,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    pcIn,
  input  logic [3:0]           opCode,
  input  logic [OFF_W-1:0]     offset,
  input  logic [TGT_W-1:0]     target,
  input  logic [ADDR_W-1:0]    rsVal,
  input  logic [ADDR_W-1:0]    rtVal,
  output logic [ADDR_W-1:0]    nextPc,
  output logic                 taken,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkDest,
  output logic [ADDR_W-1:0]    linkVal
);

  flowStrobe_t strobe;

  flow_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .opCode(opCode),
    .strobe(strobe)
  );

  flow_dp #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .TGT_W    (TGT_W),
    .REG_IDX_W(REG_IDX_W),
    .LINK_REG (LINK_REG),
    .INSN_BYTES(4)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .pcIn    (pcIn),
    .offset  (offset),
    .target  (target),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .strobe  (strobe),
    .nextPc  (nextPc),
    .taken   (taken),
    .linkWe  (linkWe),
    .linkDest(linkDest),
    .linkVal (linkVal)
  );

endmodule

// File: tb/tb_flow_npc_unit.sv
module tb_flow_npc_unit;

  typedef struct packed {
    logic [31:0] npc;
    logic        tk;
    logic        lw;
    logic [31:0] lv;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pcIn = '0;
  logic [3:0]  opCode = '0;
  logic [15:0] offset = '0;
  logic [25:0] target = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] nextPc;
  logic        taken;
  logic        linkWe;
  logic [4:0]  linkDest;
  logic [31:0] linkVal;

  int testCount = 0;
  int failCount = 0;
  expItem_t expQ[$];
  string    tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  flow_npc_unit dut (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .opCode(opCode), .offset(offset),
    .target(target), .rsVal(rsVal), .rtVal(rtVal), .nextPc(nextPc),
    .taken(taken), .linkWe(linkWe), .linkDest(linkDest), .linkVal(linkVal)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, expv);
    end
  endtask

  // Independent reference from the requirements
  function automatic expItem_t predict(input int op, input logic [31:0] pc,
      input logic [15:0] off, input logic [25:0] tgt,
      input logic [31:0] rs, input logic [31:0] rt);
    expItem_t e;
    int  sr;
    bit  c;
    int  disp;
    sr = $signed(rs);
    disp = $signed({{16{off[15]}}, off}) * 4;
    c = 1'b0;
    e.tk = 1'b0;
    e.lw = 1'b0;
    e.lv = pc + 32'd8;
    e.npc = pc + 32'd4;
    case (op)
      1: c = (rs == rt);
      2: c = (rs != rt);
      3: c = (sr <= 0);
      4: c = (sr > 0);
      5, 7: c = (sr < 0);
      6, 8: c = (sr >= 0);
      default: c = 1'b0;
    endcase
    if (op >= 1 && op <= 8 && c) begin
      e.tk = 1'b1;
      e.npc = pc + 32'd4 + 32'(disp);
      e.lw = (op == 7 || op == 8);
    end
    if (op == 9 || op == 10) begin
      e.tk = 1'b1;
      e.npc = ((pc + 32'd4) & 32'hF000_0000) | {4'h0, tgt, 2'b00};
      e.lw = (op == 10);
    end
    if (op == 11 || op == 12) begin
      e.tk = 1'b1;
      e.npc = rs;
      e.lw = (op == 12);
    end
    return e;
  endfunction

  task automatic apply(input int op, input logic [31:0] pc, input logic [15:0] off,
                       input logic [25:0] tgt, input logic [31:0] rs,
                       input logic [31:0] rt, input string tag);
    @(negedge clk);
    opCode = 4'(op);
    pcIn = pc;
    offset = off;
    target = tgt;
    rsVal = rs;
    rtVal = rt;
    expQ.push_back(predict(op, pc, off, tgt, rs, rt));
    tagQ.push_back(tag);
  endtask

  // Monitor: one result per edge, compared after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(taken == e.tk, t, "taken", {31'b0, taken}, {31'b0, e.tk});
        check(nextPc == e.npc, t, "nextPc", nextPc, e.npc);
        check(linkWe == e.lw, t, "linkWe", {31'b0, linkWe}, {31'b0, e.lw});
        if (e.lw) begin
          check(linkVal == e.lv, {t, "/R7"}, "linkVal", linkVal, e.lv);
          check(linkDest == 5'd31, {t, "/R7"}, "linkDest", {27'b0, linkDest}, 32'd31);
        end else begin
          check(linkDest == 5'd0, {t, "/R7"}, "linkDest idle", {27'b0, linkDest}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pcIn = 32'h0000_1000; opCode = 4'd10; rsVal = 32'h1234;
    @(negedge clk);
    // R1: outputs held at zero during reset despite active inputs
    check(nextPc == 0, "R1", "nextPc", nextPc, 0);
    check(taken == 0 && linkWe == 0, "R1", "taken/linkWe", {30'b0, taken, linkWe}, 0);
    check(linkDest == 0 && linkVal == 0, "R1", "link fields", linkVal, 0);
    rstN = 1'b1;
    opCode = 4'd0;

    // R2 R10: sequential
    apply(0, 32'h0040_0000, 16'h0010, 26'h0, 32'h5, 32'h5, "R2");
    // R4: equal / not equal
    apply(1, 32'h0040_0100, 16'h0008, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4");
    apply(1, 32'h0040_0100, 16'h0008, 26'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEE, "R4");
    apply(2, 32'h0040_0200, 16'h0004, 26'h0, 32'h1, 32'h8000_0001, "R4");
    apply(2, 32'h0040_0200, 16'h0004, 26'h0, 32'h7, 32'h7, "R4");
    // R3: backward displacement
    apply(1, 32'h0040_0300, 16'hFFFF, 26'h0, 32'h0, 32'h0, "R3");
    apply(2, 32'h0000_0010, 16'h8000, 26'h0, 32'h0, 32'h1, "R3");
    // R5: signed compare with zero, rt ignored
    apply(3, 32'h0040_0400, 16'h0020, 26'h0, 32'h0, 32'hFFFF_FFFF, "R5");
    apply(3, 32'h0040_0400, 16'h0020, 26'h0, 32'h1, 32'h0, "R5");
    apply(3, 32'h0040_0400, 16'h0020, 26'h0, 32'h8000_0000, 32'h1, "R5");
    apply(4, 32'h0040_0500, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, "R5");
    apply(4, 32'h0040_0500, 16'h0002, 26'h0, 32'h1, 32'h0, "R5");
    apply(4, 32'h0040_0500, 16'h0002, 26'h0, 32'h0, 32'h5, "R5");
    apply(5, 32'h0040_0600, 16'h0003, 26'h0, 32'hFFFF_FFFF, 32'h0, "R5");
    apply(5, 32'h0040_0600, 16'h0003, 26'h0, 32'h0, 32'hFFFF_FFFF, "R5");
    apply(6, 32'h0040_0700, 16'h0005, 26'h0, 32'h0, 32'hFFFF_FFFF, "R5");
    apply(6, 32'h0040_0700, 16'h0005, 26'h0, 32'h8000_0000, 32'h0, "R5");
    // R6: conditional link
    apply(7, 32'h0040_0800, 16'h0010, 26'h0, 32'hFFFF_FFF0, 32'h0, "R6");
    apply(7, 32'h0040_0800, 16'h0010, 26'h0, 32'h0, 32'h0, "R6");
    apply(8, 32'h0040_0900, 16'hFFF0, 26'h0, 32'h0, 32'h0, "R6");
    apply(8, 32'h0040_0900, 16'hFFF0, 26'h0, 32'h8000_0000, 32'h0, "R6");
    // R8: absolute jump, upper bits from pc+4 crossing into bit 28
    apply(9, 32'h1FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, "R8");
    apply(9, 32'hA000_0040, 16'h0, 26'h012_3456, 32'h0, 32'h0, "R8");
    apply(10, 32'h0040_0A00, 16'h0, 26'h000_0100, 32'h0, 32'h0, "R8");
    // R9: register jumps
    apply(11, 32'h0040_0B00, 16'h0, 26'h0, 32'h8765_4321, 32'h0, "R9");
    apply(12, 32'hFFFF_FFF8, 16'h0, 26'h0, 32'h0000_0004, 32'h0, "R9");
    // R10: unused codes
    apply(13, 32'h0040_0C00, 16'h0004, 26'h1, 32'h0, 32'h0, "R10");
    apply(15, 32'h0040_0D00, 16'h0004, 26'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    apply(0, 32'h0040_0E00, 16'h0, 26'h0, 32'h0, 32'h0, "R2");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule